// File: doc/BRIEF.md
# Freeze-Gated Audio Control Register Bank

This block is the byte-wide control register bank of a multi-channel audio converter. A host writes and reads it through a plain register port: an address, a write data byte and a write strobe, with a read data byte returned combinationally for the current address. The block drives the active settings in parallel to the converter datapath. These settings are the per-channel mute, volume and polarity-invert controls for the playback (DAC) and capture (ADC) paths. The block also holds a master clock ratio select field and an auxiliary port format bit.

The mute, volume and invert registers form a protected group, and each register in the group has a shadow copy and an active copy. A freeze bit controls the group. While freeze is clear, host writes reach both copies together. While freeze is set, writes go only to the shadow copies and the datapath keeps the old settings. When freeze is cleared, every pending shadow value is moved to the active side on a single clock edge, so a set of gain or mute changes takes effect at the same moment. The clock-select and miscellaneous registers are never held back.

Address map (byte addresses): 03h clock select, 04h miscellaneous, 05h DAC mute mask, 06h ADC mute mask, 07h DAC invert mask, 08h ADC invert mask, 10h+i DAC volume of channel i, 18h+j ADC volume of channel j. Bit i of each mask register belongs to channel i. With the default configuration there are 6 DAC channels and 4 ADC channels.

Top module: `frz_ctl_bank`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) sets every register, including the shadow copies, to 0. All outputs are 0 afterwards, and reading any address returns 0.
- R2: Address 03h holds a 3-bit master clock select in bits [3:1]. It drives mclk_sel_o from the edge that takes the write onward. Bits 7:4 and bit 0 cannot be written and read back as 0.
- R3: Address 04h bit 7 is the freeze flag. Bit 6 is the auxiliary format (0 = left justified, 1 = I2S), driven on aux_i2s_o. Bits 5:0 read back as 0.
- R4: While freeze is 0, a write to a protected register (05h–08h, 10h+i, 18h+j) changes the matching output on the edge that takes the write.
- R5: While freeze is 1, writes to protected registers leave every mute, invert and volume output unchanged.
- R6: While freeze is 1, reading a protected register returns the last value written to it (the pending value), not the active one.
- R7: The write that clears freeze changes no protected output on its own edge. On the next edge, every pending value reaches the outputs together.
- R8: Writes to 03h and 04h take effect immediately whatever the freeze state, and writing 04h with bit 7 still set keeps the group frozen.
- R9: Writes to unmapped addresses have no effect on any output or readable register, and reading an unmapped address returns 0.
- R10: Mask bits above the channel count (bits 7:6 of 05h/07h and bits 7:4 of 06h/08h in the default configuration) cannot be written and read back as 0.
- R11: A reset applied while values are pending discards them. After the reset, clearing freeze commits nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe, sampled at the rising edge |
| addr | input | 8 | Register byte address for both read and write |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr (combinational) |
| dac_mute_o | output | N_DAC | Active DAC mute per channel |
| adc_mute_o | output | N_ADC | Active ADC mute per channel |
| dac_inv_o | output | N_DAC | Active DAC polarity invert per channel |
| adc_inv_o | output | N_ADC | Active ADC polarity invert per channel |
| dac_vol_o | output | 8*N_DAC | Active DAC volume codes, channel i in bits [8i+7:8i] |
| adc_vol_o | output | 8*N_ADC | Active ADC volume codes, channel j in bits [8j+7:8j] |
| mclk_sel_o | output | 3 | Master clock ratio select |
| aux_i2s_o | output | 1 | Auxiliary port format, 1 = I2S |

## Verification
The bench writes all 256 addresses with freeze clear and sweeps the whole read space, so a decoder that aliases an unmapped or reserved bit shows up as a nonzero byte or a moved output. It then writes every protected register while frozen. A design that leaks frozen writes shows a moved output, and a design that returns active data on readback shows stale bytes. On the clearing write it checks that the outputs are still old on that edge and all new one edge later. A commit that comes one cycle early, comes one cycle late, or arrives channel by channel is therefore caught. Reset under pending values and a freeze/unfreeze pair with nothing written both target a design that keeps stale shadow data.

// File: rtl/frz_pkg.sv
package frz_pkg;
  localparam int DW = 8;
  localparam int AW = 8;

  localparam logic [AW-1:0] ADDR_CLKSEL = 8'h03;
  localparam logic [AW-1:0] ADDR_MISC   = 8'h04;
  localparam logic [AW-1:0] ADDR_DMUTE  = 8'h05;
  localparam logic [AW-1:0] ADDR_AMUTE  = 8'h06;
  localparam logic [AW-1:0] ADDR_DINV   = 8'h07;
  localparam logic [AW-1:0] ADDR_AINV   = 8'h08;
  localparam logic [AW-1:0] ADDR_DVOL   = 8'h10;
  localparam logic [AW-1:0] ADDR_AVOL   = 8'h18;

  localparam int MISC_FREEZE_BIT = 7;
  localparam int MISC_AUX_BIT    = 6;
  localparam int CLK_LSB         = 1;
  localparam int CLK_W           = 3;

  // Protected slot order: DAC mute, ADC mute, DAC invert, ADC invert,
  // DAC volumes, ADC volumes.
  function automatic logic [AW-1:0] slot_addr(input int idx, input int nd);
    logic [AW-1:0] a;
    case (idx)
      0:       a = ADDR_DMUTE;
      1:       a = ADDR_AMUTE;
      2:       a = ADDR_DINV;
      3:       a = ADDR_AINV;
      default: a = (idx < 4 + nd) ? ADDR_DVOL + AW'(idx - 4)
                                  : ADDR_AVOL + AW'(idx - 4 - nd);
    endcase
    return a;
  endfunction

  function automatic logic [DW-1:0] slot_mask(input int idx, input int nd, input int na);
    logic [DW-1:0] m;
    case (idx)
      0, 2:    m = DW'((1 << nd) - 1);
      1, 3:    m = DW'((1 << na) - 1);
      default: m = '1;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/frz_shadow_cell.sv
module frz_shadow_cell #(
  parameter int W = 8,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_hit,
  input  logic [W-1:0] wdata,
  input  logic         freeze,
  output logic [W-1:0] shadow_o,
  output logic [W-1:0] active_o
);
  logic [W-1:0] shadow_q, active_q;
  logic [W-1:0] wmasked;

  assign wmasked = wdata & MASK;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q <= '0;
      active_q <= '0;
    end else begin
      if (wr_hit) shadow_q <= wmasked;
      // Unfrozen: a write goes straight through; otherwise the active copy
      // follows the shadow, which commits pending data one edge after release.
      if (!freeze) active_q <= wr_hit ? wmasked : shadow_q;
    end
  end

  assign shadow_o = shadow_q;
  assign active_o = active_q;
endmodule

// File: rtl/frz_addr_dec.sv
module frz_addr_dec
  import frz_pkg::*;
#(
  parameter int N_DAC = 6,
  parameter int N_ADC = 4,
  localparam int NSLOT = 4 + N_DAC + N_ADC
) (
  input  logic [AW-1:0]    addr,
  output logic [NSLOT-1:0] slot_hit,
  output logic             clk_hit,
  output logic             misc_hit
);
  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    localparam logic [AW-1:0] SA = slot_addr(s, N_DAC);
    assign slot_hit[s] = (addr == SA);
  end

  assign clk_hit  = (addr == ADDR_CLKSEL);
  assign misc_hit = (addr == ADDR_MISC);
endmodule

// File: rtl/frz_rd_mux.sv
module frz_rd_mux
  import frz_pkg::*;
#(
  parameter int NSLOT = 14
) (
  input  logic [NSLOT-1:0]    slot_hit,
  input  logic [NSLOT*DW-1:0] slot_val,
  input  logic                clk_hit,
  input  logic [DW-1:0]       clk_val,
  input  logic                misc_hit,
  input  logic [DW-1:0]       misc_val,
  output logic [DW-1:0]       rdata
);
  always_comb begin
    rdata = '0;
    for (int s = 0; s < NSLOT; s++)
      if (slot_hit[s]) rdata = rdata | slot_val[s*DW +: DW];
    if (clk_hit)  rdata = rdata | clk_val;
    if (misc_hit) rdata = rdata | misc_val;
  end
endmodule

// File: rtl/frz_ctl_bank.sv
module frz_ctl_bank
  import frz_pkg::*;
#(
  parameter int N_DAC = 6,
  parameter int N_ADC = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [7:0]         addr,
  input  logic [7:0]         wdata,
  output logic [7:0]         rdata,
  output logic [N_DAC-1:0]   dac_mute_o,
  output logic [N_ADC-1:0]   adc_mute_o,
  output logic [N_DAC-1:0]   dac_inv_o,
  output logic [N_ADC-1:0]   adc_inv_o,
  output logic [8*N_DAC-1:0] dac_vol_o,
  output logic [8*N_ADC-1:0] adc_vol_o,
  output logic [2:0]         mclk_sel_o,
  output logic               aux_i2s_o
);
  localparam int NSLOT   = 4 + N_DAC + N_ADC;
  localparam int DVOL_S0 = 4;
  localparam int AVOL_S0 = 4 + N_DAC;

  logic [NSLOT-1:0]    slot_hit;
  logic                clk_hit, misc_hit;
  logic [NSLOT*DW-1:0] shadow_flat, active_flat;
  logic [CLK_W-1:0]    mclk_sel_q;
  logic                freeze_q, aux_q;
  logic [DW-1:0]       clk_rd, misc_rd;

  frz_addr_dec #(.N_DAC(N_DAC), .N_ADC(N_ADC)) u_dec (
    .addr(addr), .slot_hit(slot_hit), .clk_hit(clk_hit), .misc_hit(misc_hit)
  );

  for (genvar s = 0; s < NSLOT; s++) begin : g_cell
    frz_shadow_cell #(.W(DW), .MASK(slot_mask(s, N_DAC, N_ADC))) u_cell (
      .clk(clk), .rst(rst),
      .wr_hit(wr_en & slot_hit[s]),
      .wdata(wdata),
      .freeze(freeze_q),
      .shadow_o(shadow_flat[s*DW +: DW]),
      .active_o(active_flat[s*DW +: DW])
    );
  end

  // Plain registers: never held back by freeze.
  always_ff @(posedge clk) begin
    if (rst) begin
      mclk_sel_q <= '0;
      freeze_q   <= 1'b0;
      aux_q      <= 1'b0;
    end else if (wr_en) begin
      if (clk_hit) mclk_sel_q <= wdata[CLK_LSB +: CLK_W];
      if (misc_hit) begin
        freeze_q <= wdata[MISC_FREEZE_BIT];
        aux_q    <= wdata[MISC_AUX_BIT];
      end
    end
  end

  always_comb begin
    clk_rd  = '0;
    clk_rd[CLK_LSB +: CLK_W] = mclk_sel_q;
    misc_rd = '0;
    misc_rd[MISC_FREEZE_BIT] = freeze_q;
    misc_rd[MISC_AUX_BIT]    = aux_q;
  end

  frz_rd_mux #(.NSLOT(NSLOT)) u_rd (
    .slot_hit(slot_hit), .slot_val(shadow_flat),
    .clk_hit(clk_hit), .clk_val(clk_rd),
    .misc_hit(misc_hit), .misc_val(misc_rd),
    .rdata(rdata)
  );

  assign dac_mute_o = active_flat[0*DW +: N_DAC];
  assign adc_mute_o = active_flat[1*DW +: N_ADC];
  assign dac_inv_o  = active_flat[2*DW +: N_DAC];
  assign adc_inv_o  = active_flat[3*DW +: N_ADC];

  for (genvar i = 0; i < N_DAC; i++) begin : g_dvol
    assign dac_vol_o[i*DW +: DW] = active_flat[(DVOL_S0+i)*DW +: DW];
  end
  for (genvar j = 0; j < N_ADC; j++) begin : g_avol
    assign adc_vol_o[j*DW +: DW] = active_flat[(AVOL_S0+j)*DW +: DW];
  end

  assign mclk_sel_o = mclk_sel_q;
  assign aux_i2s_o  = aux_q;
endmodule

// File: rtl/frz_ctl_bank_chk.sv
module frz_ctl_bank_chk
  import frz_pkg::*;
#(
  parameter int N_DAC = 6,
  parameter int N_ADC = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               wr_en,
  input logic [7:0]         addr,
  input logic [7:0]         wdata,
  input logic [7:0]         rdata,
  input logic [N_DAC-1:0]   dac_mute_o,
  input logic [N_ADC-1:0]   adc_mute_o,
  input logic [N_DAC-1:0]   dac_inv_o,
  input logic [N_ADC-1:0]   adc_inv_o,
  input logic [8*N_DAC-1:0] dac_vol_o,
  input logic [8*N_ADC-1:0] adc_vol_o,
  input logic [2:0]         mclk_sel_o,
  input logic               aux_i2s_o,
  input logic               freeze_q
);
  a_r1_reset_clears: assert property (@(posedge clk)
    $past(rst) |-> (dac_mute_o == '0 && adc_mute_o == '0 && dac_inv_o == '0 &&
                    adc_inv_o == '0 && dac_vol_o == '0 && adc_vol_o == '0 &&
                    mclk_sel_o == '0 && !aux_i2s_o));

  a_r2_clksel_direct: assert property (@(posedge clk) disable iff (rst)
    wr_en && addr == ADDR_CLKSEL |=> mclk_sel_o == $past(wdata[3:1]));

  a_r3_aux_direct: assert property (@(posedge clk) disable iff (rst)
    wr_en && addr == ADDR_MISC |=> aux_i2s_o == $past(wdata[6]));

  a_r4_vol_direct: assert property (@(posedge clk) disable iff (rst)
    wr_en && !freeze_q && addr == ADDR_DVOL |=> dac_vol_o[7:0] == $past(wdata));

  a_r5_frozen_hold: assert property (@(posedge clk) disable iff (rst)
    freeze_q |=> ($stable(dac_mute_o) && $stable(adc_mute_o) && $stable(dac_inv_o) &&
                  $stable(adc_inv_o) && $stable(dac_vol_o) && $stable(adc_vol_o)));

  a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    addr == 8'h00 |-> rdata == 8'h00);
endmodule

bind frz_ctl_bank frz_ctl_bank_chk #(.N_DAC(N_DAC), .N_ADC(N_ADC)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
  .dac_mute_o(dac_mute_o), .adc_mute_o(adc_mute_o), .dac_inv_o(dac_inv_o),
  .adc_inv_o(adc_inv_o), .dac_vol_o(dac_vol_o), .adc_vol_o(adc_vol_o),
  .mclk_sel_o(mclk_sel_o), .aux_i2s_o(aux_i2s_o), .freeze_q(freeze_q)
);

// File: tb/frz_ctl_bank_tb_top.sv
`timescale 1ns/1ps
module frz_ctl_bank_tb_top;
  localparam int ND = 6;
  localparam int NA = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [7:0] addr = '0, wdata = '0;
  logic [7:0] rdata;
  logic [ND-1:0] dac_mute_o, dac_inv_o;
  logic [NA-1:0] adc_mute_o, adc_inv_o;
  logic [8*ND-1:0] dac_vol_o;
  logic [8*NA-1:0] adc_vol_o;
  logic [2:0] mclk_sel_o;
  logic aux_i2s_o;

  always #10 clk = ~clk;

  frz_ctl_bank #(.N_DAC(ND), .N_ADC(NA)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .dac_mute_o(dac_mute_o), .adc_mute_o(adc_mute_o), .dac_inv_o(dac_inv_o),
    .adc_inv_o(adc_inv_o), .dac_vol_o(dac_vol_o), .adc_vol_o(adc_vol_o),
    .mclk_sel_o(mclk_sel_o), .aux_i2s_o(aux_i2s_o)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] sh_m [256];
  logic [7:0] ac_m [256];
  bit frz_m = 0;

  function automatic logic [7:0] mask_of(input int a);
    if (a == 8'h03) return 8'h0E;
    if (a == 8'h04) return 8'hC0;
    if (a == 8'h05 || a == 8'h07) return 8'((1 << ND) - 1);
    if (a == 8'h06 || a == 8'h08) return 8'((1 << NA) - 1);
    if (a >= 8'h10 && a < 8'h10 + ND) return 8'hFF;
    if (a >= 8'h18 && a < 8'h18 + NA) return 8'hFF;
    return 8'h00;
  endfunction

  function automatic bit is_prot(input int a);
    return (a >= 5 && a <= 8) || (a >= 8'h10 && a < 8'h10 + ND) ||
           (a >= 8'h18 && a < 8'h18 + NA);
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic check_outs(input string tag);
    logic [8*ND-1:0] dv;
    logic [8*NA-1:0] av;
    for (int i = 0; i < ND; i++) dv[i*8 +: 8] = ac_m[8'h10 + i];
    for (int j = 0; j < NA; j++) av[j*8 +: 8] = ac_m[8'h18 + j];
    chk({tag, " dac_mute"}, 64'(dac_mute_o), 64'(ac_m[5][ND-1:0]));
    chk({tag, " adc_mute"}, 64'(adc_mute_o), 64'(ac_m[6][NA-1:0]));
    chk({tag, " dac_inv"},  64'(dac_inv_o),  64'(ac_m[7][ND-1:0]));
    chk({tag, " adc_inv"},  64'(adc_inv_o),  64'(ac_m[8][NA-1:0]));
    chk({tag, " dac_vol"},  64'(dac_vol_o),  64'(dv));
    chk({tag, " adc_vol"},  64'(adc_vol_o),  64'(av));
    chk({tag, " mclk_sel"}, 64'(mclk_sel_o), 64'(ac_m[3][3:1]));
    chk({tag, " aux_i2s"},  64'(aux_i2s_o),  64'(ac_m[4][6]));
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic tick(input logic we, input logic [7:0] a, input logic [7:0] d,
                      input string tag);
    wr_en = we; addr = a; wdata = d;
    @(posedge clk);
    if (!frz_m)
      for (int k = 0; k < 256; k++) if (is_prot(k)) ac_m[k] = sh_m[k];
    if (we) begin
      if (is_prot(a)) begin
        sh_m[a] = d & mask_of(a);
        if (!frz_m) ac_m[a] = d & mask_of(a);
      end else begin
        sh_m[a] = d & mask_of(a);
        ac_m[a] = d & mask_of(a);
      end
    end
    frz_m = sh_m[4][7];
    @(negedge clk);
    wr_en = 1'b0;
    check_outs(tag);
  endtask

  task automatic do_reset(input string tag);
    rst = 1'b1; wr_en = 1'b0;
    @(posedge clk);
    for (int k = 0; k < 256; k++) begin sh_m[k] = '0; ac_m[k] = '0; end
    frz_m = 0;
    @(negedge clk);
    rst = 1'b0;
    check_outs(tag);
  endtask

  task automatic read_sweep(input string tag);
    for (int k = 0; k < 256; k++) begin
      addr = 8'(k);
      #1;
      chk($sformatf("%s read %02h", tag, k), 64'(rdata), 64'(sh_m[k]));
    end
    @(negedge clk);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog act=hung exp=finished");
      summary();
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset("R1 reset");
    read_sweep("R1 R9 after reset");

    // Unfrozen sweep over every address except the control register.
    for (int a = 0; a < 256; a++)
      if (a != 4) tick(1'b1, 8'(a), 8'(a * 37 + 11), "R4 R2 R9 R10 unfrozen write");
    tick(1'b1, 8'h04, 8'h7F, "R3 misc reserved bits");
    tick(1'b0, 8'h00, 8'h00, "R4 idle");
    read_sweep("R2 R3 R9 R10 readback");

    // Freeze and rewrite the whole protected group.
    tick(1'b1, 8'h04, 8'h80, "R3 freeze on");
    for (int a = 0; a < 256; a++)
      if (is_prot(a)) tick(1'b1, 8'(a), 8'(a * 91 + 5), "R5 frozen write");
    tick(1'b1, 8'h03, 8'hFF, "R8 clksel during freeze");
    tick(1'b1, 8'h04, 8'hC0, "R8 aux during freeze");
    tick(1'b1, 8'h05, 8'h2A, "R5 still frozen");
    tick(1'b1, 8'hFE, 8'hFF, "R9 unmapped while frozen");
    read_sweep("R6 pending readback");

    // Release: no change on the clearing edge, all change on the next one.
    tick(1'b1, 8'h04, 8'h40, "R7 clearing edge");
    tick(1'b0, 8'h00, 8'h00, "R7 commit edge");
    tick(1'b0, 8'h00, 8'h00, "R7 settled");
    read_sweep("R7 after commit");

    // Reset with pending values, then release.
    tick(1'b1, 8'h04, 8'h80, "R11 freeze on");
    tick(1'b1, 8'h10, 8'h55, "R11 pending");
    tick(1'b1, 8'h06, 8'h0F, "R11 pending");
    do_reset("R11 reset under freeze");
    tick(1'b1, 8'h04, 8'h00, "R11 release after reset");
    tick(1'b0, 8'h00, 8'h00, "R11 nothing committed");
    read_sweep("R11 readback");

    // Freeze/unfreeze with nothing pending, then a direct write after.
    tick(1'b1, 8'h12, 8'h3C, "R4 direct");
    tick(1'b1, 8'h04, 8'h80, "R5 freeze again");
    tick(1'b1, 8'h04, 8'h00, "R7 empty release");
    tick(1'b0, 8'h00, 8'h00, "R7 empty commit");
    tick(1'b1, 8'h1B, 8'hA5, "R4 direct after release");
    tick(1'b0, 8'h00, 8'h00, "R4 idle");

    done = 1;
    summary();
    $finish;
  end
endmodule